// File: doc/BRIEF.md
# Serial EEPROM Device Model (Microwire-style, 64 x 16)

This block sits on the device side of a four-wire serial link (chip select, serial clock, data in, data out) and behaves like a small serial EEPROM of 64 words of 16 bits. The host raises chip select and shifts in a command, MSB first, on rising serial-clock edges. A command is a start bit of 1, a 2-bit operation code and a 6-bit word address. A read returns one leading 0 and then the addressed word. Write, erase, fill-all, clear-all, enable-programming and disable-programming are also decoded.

Storage is an internal register array. It is clocked by the system clock `clk`, and the serial clock is sampled and edge-detected in that domain. Programming delays are taken as instant: a modifying command completes on the serial edge that carries its last bit. A programming-enable flag gates every command that changes storage. When the flag is clear, such commands are still shifted in fully, but they leave the array untouched.

Top module: `uwire_eeprom_model`

## Requirements
- R1: A command begins with the first 1 sampled on a rising `sk` edge while `cs` is high; zeros before it are skipped. It is followed by a 2-bit operation code and a 6-bit address, both MSB first.
- R2: Operation code 2'b10 reads. On the rising edge that carries the last address bit, `dout` becomes 0. Each of the next 16 rising edges presents one stored bit, bit 15 first.
- R3: Operation code 2'b01 writes. The address is followed by 16 data bits, bit 15 first, and the word is stored at the 16th data edge.
- R4: Operation code 2'b11 sets the addressed word to 16'hFFFF.
- R5: With operation code 2'b00, address bits [5:4] = 2'b11 set the programming-enable flag and 2'b00 clear it. Address bits [3:0] are ignored.
- R6: With operation code 2'b00, address bits [5:4] = 2'b10 set every word to 16'hFFFF. Address bits [5:4] = 2'b01 take 16 data bits and store them into every word.
- R7: The programming-enable flag is clear after reset. Write, erase, fill-all and clear-all commands received while the flag is clear change no stored word.
- R8: A low `cs` aborts any partial command and returns the decoder to waiting for a start bit. This holds even when `cs` falls in the same cycle as a rising `sk` edge.
- R9: `dout` is 0 whenever `cs` is low, during non-read commands, and after the 16th read bit.
- R10: After reset every stored word holds 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock; rising edges shift bits |
| di | input | 1 | Serial data into the device |
| dout | output | 1 | Serial data out of the device |

## Verification
Two events can land in the same system-clock cycle: a rising serial-clock edge that completes a write, and the fall of chip select that must abort it. The bench provokes this by lowering `cs` and raising `sk` together on the 16th data bit of a write. It then reads the word back through the normal read command and expects the old value, which shows that the abort took priority over the commit. Read-back words are compared against a bench-side model of the array that is updated only from the requirements.

// File: rtl/uwire_eeprom_model.sv
module uwire_eeprom_model #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic dout
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int CMD_W = ADDR_W + 2;
  localparam int CNT_W = $clog2(DATA_W + 1) + 1;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_DATA, S_READ, S_DONE} st_t;

  st_t                state;
  logic [CNT_W-1:0]   cnt;
  logic [CMD_W-1:0]   cmd_sr;
  logic [DATA_W-1:0]  data_sr, rd_sr;
  logic [ADDR_W-1:0]  addr_q;
  logic               wral_q, prog_en, dout_r, sk_q;
  logic [DATA_W-1:0]  mem [WORDS];

  logic               mem_we, mem_all;
  logic [ADDR_W-1:0]  mem_wa;
  logic [DATA_W-1:0]  mem_wd;

  wire               sk_rise  = sk & ~sk_q;
  wire [CMD_W-1:0]   cmd_full = {cmd_sr[CMD_W-2:0], di};
  wire [1:0]         op       = cmd_full[CMD_W-1 -: 2];
  wire [ADDR_W-1:0]  adr_in   = cmd_full[ADDR_W-1:0];
  wire [1:0]         ext      = adr_in[ADDR_W-1 -: 2];
  wire [DATA_W-1:0]  dat_full = {data_sr[DATA_W-2:0], di};
  wire               cmd_last = (cnt == CNT_W'(CMD_W - 1));
  wire               dat_last = (cnt == CNT_W'(DATA_W - 1));

  assign dout = cs & (state == S_READ) & dout_r;

  always_comb begin
    mem_we  = 1'b0;
    mem_all = 1'b0;
    mem_wa  = addr_q;
    mem_wd  = dat_full;
    if (cs && sk_rise) begin
      if (state == S_CMD && cmd_last) begin
        if (op == 2'b11) begin
          mem_we = prog_en;
          mem_wa = adr_in;
          mem_wd = '1;
        end else if (op == 2'b00 && ext == 2'b10) begin
          mem_we  = prog_en;
          mem_all = 1'b1;
          mem_wd  = '1;
        end
      end else if (state == S_DATA && dat_last) begin
        mem_we  = prog_en;
        mem_all = wral_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (mem_we) begin
      if (mem_all) begin
        for (int i = 0; i < WORDS; i++) mem[i] <= mem_wd;
      end else begin
        mem[mem_wa] <= mem_wd;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      cmd_sr  <= '0;
      data_sr <= '0;
      rd_sr   <= '0;
      addr_q  <= '0;
      wral_q  <= 1'b0;
      prog_en <= 1'b0;
      dout_r  <= 1'b0;
      sk_q    <= 1'b0;
    end else begin
      sk_q <= sk;
      if (!cs) begin
        state  <= S_IDLE;
        cnt    <= '0;
        dout_r <= 1'b0;
      end else if (sk_rise) begin
        case (state)
          S_IDLE: if (di) begin
            state <= S_CMD;
            cnt   <= '0;
          end
          S_CMD: begin
            cmd_sr <= cmd_full;
            cnt    <= cnt + 1'b1;
            if (cmd_last) begin
              cnt    <= '0;
              addr_q <= adr_in;
              wral_q <= 1'b0;
              state  <= S_DONE;
              case (op)
                2'b10: begin
                  state  <= S_READ;
                  rd_sr  <= mem[adr_in];
                  dout_r <= 1'b0;
                end
                2'b01: state <= S_DATA;
                2'b11: ;
                default: begin
                  case (ext)
                    2'b11: prog_en <= 1'b1;
                    2'b00: prog_en <= 1'b0;
                    2'b01: begin
                      wral_q <= 1'b1;
                      state  <= S_DATA;
                    end
                    default: ;
                  endcase
                end
              endcase
            end
          end
          S_DATA: begin
            data_sr <= dat_full;
            cnt     <= cnt + 1'b1;
            if (dat_last) state <= S_DONE;
          end
          S_READ: begin
            if (cnt < CNT_W'(DATA_W)) begin
              dout_r <= rd_sr[DATA_W-1];
              rd_sr  <= rd_sr << 1;
              cnt    <= cnt + 1'b1;
            end else begin
              dout_r <= 1'b0;
              state  <= S_DONE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/uwire_eeprom_model_chk.sv
module uwire_eeprom_model_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic dout,
  input logic sk_rise,
  input logic prog_en
);
  // R9
  dout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !dout);

  // R2
  dout_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && $past(cs) && !$stable(dout)) |-> $past(sk_rise));

  // R5
  en_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_en) |-> $past(cs && sk_rise));

  // R8
  dout_prior_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout |-> $past(cs));
endmodule

bind uwire_eeprom_model uwire_eeprom_model_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs(cs), .dout(dout),
  .sk_rise(sk_rise), .prog_en(prog_en)
);

// File: tb/uwire_eeprom_model_tb_top.sv
module uwire_eeprom_model_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic dout;
  int checks = 0, errors = 0;
  logic [15:0] model [64];
  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic [15:0] got_word;
  event        got_ev;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  uwire_eeprom_model dut_i (.clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .dout(dout));

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_out(logic b);
    @(negedge clk); di = b; sk = 1'b0;
    repeat (2) @(negedge clk);
    sk = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_on();
    @(negedge clk); cs = 1'b1; sk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_off();
    @(negedge clk); sk = 1'b0;
    @(negedge clk); cs = 1'b0;
    repeat (2) @(negedge clk);
    check(dout === 1'b0, "R9 cs low", {15'd0, dout}, 16'h0);
  endtask

  task automatic send_cmd(logic [1:0] op, logic [5:0] a, int lead);
    cs_on();
    for (int i = 0; i < lead; i++) bit_out(1'b0);
    bit_out(1'b1);
    for (int i = 1; i >= 0; i--) bit_out(op[i]);
    for (int i = 5; i >= 0; i--) bit_out(a[i]);
  endtask

  task automatic send_data(logic [15:0] d);
    for (int i = 15; i >= 0; i--) bit_out(d[i]);
  endtask

  task automatic rd(logic [5:0] a, int lead, string req);
    logic [15:0] w;
    send_cmd(2'b10, a, lead);
    check(dout === 1'b0, "R2 leading zero", {15'd0, dout}, 16'h0);
    exp_q.push_back(model[a]);
    tag_q.push_back(req);
    for (int i = 15; i >= 0; i--) begin
      bit_out(1'b0);
      w[i] = dout;
    end
    got_word = w;
    -> got_ev;
    bit_out(1'b0);
    check(dout === 1'b0, "R9 after read", {15'd0, dout}, 16'h0);
    cs_off();
  endtask

  task automatic ext(logic [1:0] sel, logic [3:0] low);
    send_cmd(2'b00, {sel, low}, 0);
    cs_off();
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d, bit en);
    send_cmd(2'b01, a, 0);
    send_data(d);
    check(dout === 1'b0, "R9 during write", {15'd0, dout}, 16'h0);
    cs_off();
    if (en) model[a] = d;
  endtask

  initial begin
    forever begin
      @(got_ev);
      begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(got_word === e, t, got_word, e);
      end
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    check(dout === 1'b0, "R9 reset", {15'd0, dout}, 16'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rd(6'd0, 0, "R10 reset contents");
    rd(6'd63, 0, "R10 reset contents top");
    // R7: disabled write is consumed, storage unchanged
    wr(6'd5, 16'h1234, 1'b0);
    rd(6'd5, 0, "R7 write blocked");
    // R5: enable with low bits don't-care
    ext(2'b11, 4'b1010);
    wr(6'd5, 16'hA5C3, 1'b1);
    rd(6'd5, 0, "R3 write addr 5");
    wr(6'd63, 16'h1234, 1'b1);
    rd(6'd63, 0, "R3 write addr 63");
    // R4 erase
    send_cmd(2'b11, 6'd5, 0); cs_off(); model[5] = 16'hFFFF;
    rd(6'd5, 0, "R4 erase");
    // R6 write-all
    send_cmd(2'b00, 6'b01_0110, 0); send_data(16'h5A5A); cs_off();
    for (int i = 0; i < 64; i++) model[i] = 16'h5A5A;
    rd(6'd0, 0, "R6 write-all 0");
    rd(6'd17, 0, "R6 write-all 17");
    rd(6'd63, 0, "R6 write-all 63");
    // R6 erase-all
    ext(2'b10, 4'b0011);
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    rd(6'd40, 0, "R6 erase-all");
    // R1 leading zeros before start bit
    wr(6'd9, 16'h0F0F, 1'b1);
    rd(6'd9, 3, "R1 leading zeros");
    // R8 abort mid-data
    send_cmd(2'b01, 6'd9, 0);
    for (int i = 0; i < 8; i++) bit_out(1'b1);
    cs_off();
    rd(6'd9, 0, "R8 abort partial write");
    // R8 cs fall coincident with last data edge
    send_cmd(2'b01, 6'd10, 0);
    for (int i = 0; i < 15; i++) bit_out(1'b0);
    @(negedge clk); di = 1'b0; sk = 1'b0;
    repeat (2) @(negedge clk);
    sk = 1'b1; cs = 1'b0;
    repeat (3) @(negedge clk);
    sk = 1'b0;
    repeat (2) @(negedge clk);
    rd(6'd10, 0, "R8 same-cycle abort");
    // R5 disable, then write blocked
    ext(2'b00, 4'b1111);
    wr(6'd9, 16'h0000, 1'b0);
    rd(6'd9, 0, "R5 disable blocks write");
    send_cmd(2'b11, 6'd9, 0); cs_off();
    rd(6'd9, 0, "R7 erase blocked");
    ext(2'b10, 4'b0000);
    rd(6'd9, 0, "R7 erase-all blocked");
    repeat (4) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule